// File: doc/BRIEF.md
# Vector Base-2 Logarithm Estimator

This block estimates log2 of several single-precision floating-point values at once. It is a lane-parallel arithmetic unit. A packed input word carries one 32-bit value per lane. Each value goes through a fixed sequence of steps, and the results leave as a packed output word with the same lane layout. The design is a fully pipelined datapath: a new vector may enter on every clock cycle, with no stall and no backpressure. Each lane has its own copy of the datapath and shares nothing with its neighbours apart from the valid pipeline.

Each lane first classifies its operand. Infinities, NaNs and zeros take a bypass path that carries a precomputed result to the end. Every other value is turned into a signed fixed-point number with 23 fractional bits. A denormal operand is first normalised with a leading-zero count. Three comparison steps then find the first three fractional bits of the result. Each step tests the mantissa against a root of two. When the test succeeds, the step sets one result bit and multiplies the mantissa by the reciprocal of that root. A single linear term then fills in the remaining fraction. Finally, a leading-zero count turns the fixed-point value back into a float. The result is an estimate and is not correctly rounded.

Top module: `lg2_est`

## Requirements
- R1: `out_valid` rises exactly LAT clock cycles after `in_valid` was sampled high, one result per accepted vector, in order. LAT is 6 when PIPE_ROOTS is 1 and 4 when it is 0. A vector may be accepted on every cycle.
- R2: An operand whose exponent field (bits 30:23) is all ones is returned unchanged, except that a nonzero mantissa (NaN) also has bit 22 set. +Inf gives 0x7F800000 and NaN 0x7F800001 gives 0x7FC00001.
- R3: An operand of +0 or -0 gives 0xFF800000.
- R4: A denormal operand (exponent field zero, mantissa nonzero) is normalised by shifting the mantissa left by lz-8, where lz is the leading-zero count of the 32-bit mantissa word. Its fixed-point exponent is (-118-lz)·2^23. The smallest denormal, 0x00000001, gives 0xC3150000 (-149.0).
- R5: The three steps compare the mantissa against 0xB504F3, 0x9837F0 and 0x8B95C2, in that order. A step whose test is met sets fixed-point bit 22, 21 or 20 respectively. It also replaces the mantissa with bits 55:32 of its product with 0xB504F334, 0xD744FCCB or 0xEAC0C6E8.
- R6: If the mantissa left after the steps exceeds 0x800000, bits 56:32 of (2·(mantissa-0x800000))·0xB0C7CD3A are added to the fixed-point value.
- R7: A nonzero fixed-point value v is encoded as follows. The sign is taken from bit 31 of v, and lz is the leading-zero count of |v|. Then |v| is shifted right by 8-lz (or left when 8-lz is negative), and the output is sign·2^31 + (134-lz)·2^23 + the shifted magnitude. So 2.0 gives 0x3F800000 and 0.5 gives 0xBF800000.
- R8: A fixed-point value of exactly zero, for example from the operand 1.0 (0x3F800000), encodes as 0x00000000. The output is never -0.
- R9: Lane i uses bits 32i+31:32i of both `in_data` and `out_data`. Lanes do not affect each other. For a finite nonzero operand the sign bit is ignored, so -2.0 gives the same result as 2.0.
- R10: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Input vector present this cycle |
| in_data | input | LANES*32 (128) | Packed single-precision operands, lane 0 in the low bits |
| out_valid | output | 1 | Result vector present this cycle |
| out_data | output | LANES*32 (128) | Packed single-precision log2 estimates |

## Verification
Two different functions can meet in the same cycle: the bypass path for specials and the arithmetic path for finite operands. This happens when one input word mixes NaN, infinity or zero in some lanes with normals or denormals in others, and it also happens across consecutive words that overlap in the pipeline. The bench drives such mixed words back to back and also with idle gaps. A scoreboard judges every lane of every result separately against its expected value. The expected result for each lane depends only on that lane's operand, and every result must arrive exactly LAT cycles after its operand was accepted.

// File: rtl/lg2_pkg.sv
package lg2_pkg;

   localparam int FP_W   = 32;
   localparam int MANT_W = 24;
   localparam int NROOT  = 3;

   localparam logic [31:0] NEG_INF  = 32'hFF80_0000;
   localparam logic [23:0] ONE_MANT = 24'h80_0000;
   localparam logic [31:0] LIN_MUL  = 32'hB0C7_CD3A;

   typedef struct packed {
      logic              byp;
      logic [FP_W-1:0]   bval;
      logic [FP_W-1:0]   fx;
      logic [MANT_W-1:0] mt;
   } lg2_work_t;

   function automatic logic [23:0] root_thr(input int k);
      case (k)
         0:       return 24'hB5_04F3;
         1:       return 24'h98_37F0;
         default: return 24'h8B_95C2;
      endcase
   endfunction

   function automatic logic [31:0] root_mul(input int k);
      case (k)
         0:       return 32'hB504_F334;
         1:       return 32'hD744_FCCB;
         default: return 32'hEAC0_C6E8;
      endcase
   endfunction

   function automatic logic [5:0] clz32(input logic [31:0] v);
      logic [5:0] n;
      logic       hit;
      n   = 6'd32;
      hit = 1'b0;
      for (int i = 31; i >= 0; i--) begin
         if (!hit && v[i]) begin
            n   = 6'(31 - i);
            hit = 1'b1;
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/lg2_front.sv
module lg2_front
   import lg2_pkg::*;
(
   input  logic [FP_W-1:0] x,
   output lg2_work_t       w
);
   logic [7:0]  expf;
   logic [22:0] man;
   logic [5:0]  lz;
   logic [31:0] ebias;

   assign expf = x[30:23];
   assign man  = x[22:0];
   assign lz   = clz32({9'b0, man});

   always_comb begin
      w     = '0;
      ebias = '0;
      if (expf == 8'hFF) begin
         w.byp  = 1'b1;
         w.bval = x | {9'b0, (man != 23'd0), 22'b0};
      end else if (expf == 8'h00 && man == 23'd0) begin
         w.byp  = 1'b1;
         w.bval = NEG_INF;
      end else if (expf == 8'h00) begin
         w.mt  = 24'({9'b0, man} << (lz - 6'd8));
         ebias = 32'd0 - 32'd118 - {26'b0, lz};
         w.fx  = ebias << 23;
      end else begin
         w.mt  = {1'b1, man};
         ebias = {24'b0, expf} - 32'd127;
         w.fx  = ebias << 23;
      end
   end
endmodule

// File: rtl/lg2_root_step.sv
module lg2_root_step
   import lg2_pkg::*;
#(
   parameter int K = 0
) (
   input  lg2_work_t din,
   output lg2_work_t dout
);
   localparam logic [23:0] THR = root_thr(K);
   localparam logic [31:0] MUL = root_mul(K);
   localparam int          BIT = 22 - K;

   logic [55:0] prod;

   assign prod = 56'(din.mt) * 56'(MUL);

   always_comb begin
      dout = din;
      if (!din.byp && din.mt >= THR) begin
         dout.fx[BIT] = 1'b1;
         dout.mt      = prod[55:32];
      end
   end
endmodule

// File: rtl/lg2_linear.sv
module lg2_linear
   import lg2_pkg::*;
(
   input  lg2_work_t din,
   output lg2_work_t dout
);
   logic [24:0] dlt;
   logic [56:0] prod;

   assign dlt  = {din.mt - ONE_MANT, 1'b0};
   assign prod = 57'(dlt) * 57'(LIN_MUL);

   always_comb begin
      dout = din;
      if (!din.byp && din.mt > ONE_MANT)
         dout.fx = din.fx + {7'b0, prod[56:32]};
   end
endmodule

// File: rtl/lg2_encode.sv
module lg2_encode
   import lg2_pkg::*;
(
   input  lg2_work_t       din,
   output logic [FP_W-1:0] y
);
   logic              sgn;
   logic [31:0]       mag;
   logic [5:0]        lz;
   logic signed [9:0] sh;
   logic [9:0]        ex;
   logic [31:0]       mshift;

   assign sgn = din.fx[31];
   assign mag = sgn ? (32'd0 - din.fx) : din.fx;
   assign lz  = clz32(mag);
   assign sh  = 10'sd8 - $signed({4'b0, lz});
   assign ex  = 10'(sh + 10'sd126);

   always_comb begin
      if (sh > 10'sd0) mshift = mag >> sh[4:0];
      else             mshift = mag << 5'(-sh);
      if (din.byp)             y = din.bval;
      else if (din.fx == '0)   y = '0;
      else                     y = {sgn, 31'b0} + ({22'b0, ex} << 23) + mshift;
   end
endmodule

// File: rtl/lg2_est.sv
module lg2_est
   import lg2_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int PIPE_ROOTS = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [LANES*FP_W-1:0] in_data,
   output logic                  out_valid,
   output logic [LANES*FP_W-1:0] out_data
);
   localparam int LAT = (PIPE_ROOTS != 0) ? (NROOT + 3) : 4;

   if (LANES < 1) begin : g_bad_lanes
      $error("lg2_est: LANES must be at least 1");
   end
   if (PIPE_ROOTS != 0 && PIPE_ROOTS != 1) begin : g_bad_pipe
      $error("lg2_est: PIPE_ROOTS must be 0 or 1");
   end

   logic [LAT-1:0] vpipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[LAT-2:0], in_valid};
   end
   assign out_valid = vpipe[LAT-1];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      lg2_work_t fr_c, s1_q, lin_c, lin_q;
      logic [FP_W-1:0] enc_c, out_q;

      lg2_front u_front (.x(in_data[l*FP_W +: FP_W]), .w(fr_c));

      always_ff @(posedge clk) s1_q <= fr_c;

      for (genvar k = 0; k < NROOT; k++) begin : g_rt
         lg2_work_t d, c, q;
         if (k == 0) begin : g_first
            assign d = s1_q;
         end else begin : g_next
            assign d = g_rt[k-1].q;
         end
         lg2_root_step #(.K(k)) u_step (.din(d), .dout(c));
         if (PIPE_ROOTS != 0 || k == NROOT - 1) begin : g_reg
            always_ff @(posedge clk) q <= c;
         end else begin : g_wire
            assign q = c;
         end
      end

      lg2_linear u_lin (.din(g_rt[NROOT-1].q), .dout(lin_c));
      always_ff @(posedge clk) lin_q <= lin_c;

      lg2_encode u_enc (.din(lin_q), .y(enc_c));
      always_ff @(posedge clk) out_q <= enc_c;

      assign out_data[l*FP_W +: FP_W] = out_q;
   end
endmodule

// File: rtl/lg2_chk.sv
module lg2_chk #(
   parameter int LANES = 4,
   parameter int LAT   = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                out_valid,
   input logic [LANES*32-1:0] out_data
);
   logic [LAT-1:0] vseen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vseen <= '0;
      else        vseen <= {vseen[LAT-2:0], in_valid};
   end

   // R1: results appear exactly LAT cycles after acceptance
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vseen[LAT-1]);

   // R10: held reset keeps the output side idle
   p_reset_idle_r10: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      logic [31:0] v;
      assign v = out_data[l*32 +: 32];

      // R2: any NaN leaving the block is quiet
      p_nan_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && v[30:23] == 8'hFF && v[22:0] != 23'd0) |-> v[22]);

      // R7: finite results stay within the log2 range of single precision
      p_exp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (v[30:23] <= 8'd134 || v[30:23] == 8'hFF));

      // R8: a zero result is always positive
      p_no_negzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> v != 32'h8000_0000);
   end
endmodule

bind lg2_est lg2_chk #(.LANES(LANES), .LAT(LAT)) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .in_valid(in_valid),
   .out_valid(out_valid),
   .out_data(out_data)
);

// File: tb/sim_lg2_est.sv
module sim_lg2_est;
   localparam int LANES = 4;
   localparam int LAT   = 6;
   localparam int W     = LANES * 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         out_valid;
   logic [W-1:0] out_data;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   logic done = 1'b0;

   logic [W-1:0] exp_q[$];
   int           cyc_q[$];
   string        tag_q[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lg2_est #(.LANES(LANES), .PIPE_ROOTS(1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic int lzc(input logic [31:0] v);
      for (int i = 31; i >= 0; i--) if (v[i]) return 31 - i;
      return 32;
   endfunction

   function automatic logic [31:0] mdl(input logic [31:0] s);
      logic [31:0] e, m, fr, mag, res;
      logic [63:0] p;
      int lz, sh;
      e = s & 32'h7F80_0000;
      m = s & 32'h007F_FFFF;
      if (e == 32'h7F80_0000) return (m != 0) ? (s | 32'h0040_0000) : s;
      if (e == 0 && m == 0) return 32'hFF80_0000;
      if (e == 0) begin
         lz = lzc(m);
         m  = m << (lz - 8);
         e  = 32'(-118 - lz) << 23;
      end else begin
         m = m | 32'h0080_0000;
         e = e - (32'd127 << 23);
      end
      if (m >= 32'hB504F3) begin e |= 32'h40_0000; p = 64'(m) * 64'hB504_F334; m = p[63:32]; end
      if (m >= 32'h9837F0) begin e |= 32'h20_0000; p = 64'(m) * 64'hD744_FCCB; m = p[63:32]; end
      if (m >= 32'h8B95C2) begin e |= 32'h10_0000; p = 64'(m) * 64'hEAC0_C6E8; m = p[63:32]; end
      if (m > 32'h80_0000) begin
         p  = 64'((m - 32'h80_0000) << 1) * 64'hB0C7_CD3A;
         fr = p[63:32];
         e  = e + fr;
      end
      if (e == 0) return 32'h0;
      mag = e[31] ? -e : e;
      lz  = lzc(mag);
      sh  = 8 - lz;
      if (sh > 0) mag = mag >> sh;
      else        mag = mag << (-sh);
      res = {e[31], 31'b0} + (32'(sh + 126) << 23) + mag;
      return res;
   endfunction

   // driver: drives one vector at a negedge and queues its expectation
   task automatic send(input string tag, input logic [W-1:0] d,
                       input logic use_given, input logic [W-1:0] given);
      logic [W-1:0] ex;
      for (int l = 0; l < LANES; l++) ex[l*32 +: 32] = mdl(d[l*32 +: 32]);
      if (use_given) ex = given;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      exp_q.push_back(ex);
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = '0;
      end
   endtask

   function automatic logic [31:0] rnd_fp(input int kind);
      logic [31:0] r;
      r = $urandom;
      case (kind)
         0: r[30:23] = 8'(100 + ($urandom % 55));
         1: r[30:23] = 8'h00;
         default: ;
      endcase
      return r;
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R1 unexpected result: actual out_valid=1 expected 0 at cycle %0d", cyc);
         end else begin
            logic [W-1:0] ex;
            int c;
            string t;
            ex = exp_q.pop_front();
            c  = cyc_q.pop_front();
            t  = tag_q.pop_front();
            tests++;
            if (cyc != c + LAT) begin
               fails++;
               $display("FAIL R1 latency: actual %0d expected %0d", cyc - c, LAT);
            end
            for (int l = 0; l < LANES; l++) begin
               tests++;
               if (out_data[l*32 +: 32] !== ex[l*32 +: 32]) begin
                  fails++;
                  $display("FAIL %s R9 lane %0d: actual %08h expected %08h",
                           t, l, out_data[l*32 +: 32], ex[l*32 +: 32]);
               end
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      tests++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R10 reset: actual out_valid=%b expected 0", out_valid);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R8 (1.0 -> +0), R7 (2.0 -> 1.0, 0.5 -> -1.0), R9 sign ignored (-2.0)
      send("R7", {32'hC000_0000, 32'h3F00_0000, 32'h4000_0000, 32'h3F80_0000},
           1'b1, {32'h3F80_0000, 32'hBF80_0000, 32'h3F80_0000, 32'h0000_0000});
      // R2 specials and R3 zeros, mixed with R4 smallest denormal
      send("R2", {32'h7F80_0001, 32'h7F80_0000, 32'hFF80_0000, 32'hFFC0_1234},
           1'b1, {32'h7FC0_0001, 32'h7F80_0000, 32'hFF80_0000, 32'hFFC0_1234});
      send("R3", {32'h0000_0001, 32'h8000_0000, 32'h0000_0000, 32'h3F80_0000},
           1'b1, {32'hC315_0000, 32'hFF80_0000, 32'hFF80_0000, 32'h0000_0000});
      idle(1);
      // R5 threshold edges, R6 small excess above one
      send("R5", {32'h3FB5_04F3, 32'h3FB5_04F2, 32'h3F98_37F0, 32'h3F8B_95C2}, 1'b0, '0);
      send("R5", {32'h3FFF_FFFF, 32'h3F98_37EF, 32'h3F8B_95C1, 32'hC0B5_04F3}, 1'b0, '0);
      send("R6", {32'h3F80_0001, 32'h3F84_0000, 32'h3F8B_0000, 32'h4080_7000}, 1'b0, '0);
      // R4 denormals of several lengths
      send("R4", {32'h0040_0000, 32'h007F_FFFF, 32'h8000_0003, 32'h0000_1234}, 1'b0, '0);
      idle(3);

      // R9 mixed bypass and arithmetic lanes, back to back and with gaps
      for (int n = 0; n < 60; n++) begin
         logic [W-1:0] d;
         for (int l = 0; l < LANES; l++) d[l*32 +: 32] = rnd_fp(int'($urandom % 4));
         if (n % 7 == 3) d[31:0] = 32'h0000_0000;
         if (n % 5 == 1) d[95:64] = 32'h7FA0_0000;
         send("R7", d, 1'b0, '0);
         if (n % 9 == 8) idle(int'($urandom % 3) + 1);
      end
      idle(LAT + 4);

      tests++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R1 missing results: actual %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule